// File: doc/BRIEF.md
# Period-Latched Single-Edge PWM Timer

This block is a pulse-width-modulation timer running on the peripheral clock. A programmable prescaler divides the clock into counter ticks, and a timer counter steps on each tick. A period match value bounds the counter, and a duty match value decides the point in the period where the single output rises. A simple synchronous write port loads the control, prescale, match, mode, output-enable and latch-flag registers.

Match values written over the port go into shadow registers only. A value moves into the active match register when two things are true: its latch flag has been set, and the counter wraps at the period match. The flag then clears itself. Because of this, software can change period and duty in the middle of a period and never produces a glitched or truncated pulse. The output is low from the start of each period until the counter reaches the active duty value, and high from there until the period ends.

Register map for `wr_addr`:
- 0: control. Bit 0 runs the counter, bit 1 holds the counter in reset, bit 3 selects PWM mode. The value 0x09 starts PWM operation.
- 1: prescale.
- 2: period shadow.
- 3: duty shadow.
- 4: mode. Bit 0 restarts the counter on the period match.
- 5: output enable, bit 0.
- 6: latch flags. Bit 0 is the period, bit 1 is the duty.

Top module: `pwm_latched_timer`

## Requirements
- R1: After reset, `count_o` is 0, `pwm_o` is 0 and `latch_pend_o` is 0.
- R2: While running, the counter advances once every (prescale + 1) clocks. After the hold is released, the first advance comes (prescale + 1) clocks later.
- R3: With mode bit 0 set and active period P ≥ 1, the counter runs 0 .. P-1 and then returns to 0, so a period lasts P·(prescale+1) clocks. With mode bit 0 clear, the counter runs freely past P.
- R4: With PWM mode on and output enable set, `pwm_o` is 1 exactly while the counter is at or above the active duty value. With period 2, duty 1 and prescale 0, the output alternates on every clock.
- R5: Writes to address 2 or 3 do not alter the active period or duty. The active value changes only at a period wrap, and only if its latch flag is set.
- R6: Writing 1 to bit 0 or bit 1 of address 6 sets that pending flag, and writing 0 leaves it unchanged. Flags set by separate writes accumulate. Each flag clears on the wrap that transfers its value.
- R7: Control bit 0 enables counting. With bit 0 clear, the counter stays at its current value.
- R8: While control bit 1 is set, the counter and prescaler are held at 0 and no wrap or transfer occurs.
- R9: `pwm_o` is held low whenever output enable bit 0 or control bit 3 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Write data |
| pwm_o | output | 1 | Single-edge PWM output |
| count_o | output | W | Timer counter value |
| latch_pend_o | output | 2 | Pending latch flags (bit 0 period, bit 1 duty) |

## Verification
A table of prescale, period and duty combinations is run: half-clock toggling, mid-range duty, duty of zero (always high), duty above the period (always low) and a period of one. For each combination, the high time counted over four whole periods separates a correct duty from an off-by-one in the compare. The peak counter value separates a correct period from a period one tick too long. Directed sequences then change shadow values with and without latch flags, and under hold. These show whether transfers wait for a flagged wrap, whether flags accumulate and clear, and whether the prescaler restarts from zero. Further directed tests cover stopping the counter, free running without the period restart, and the output gating.

// File: rtl/pwm_lt_pkg.sv
// Package: shared register addresses and control bit positions for the
// period-latched PWM timer. Assumes a 3-bit register address space.
package pwm_lt_pkg;

    typedef enum logic [2:0] {
        REG_CTRL     = 3'd0,
        REG_PRESCALE = 3'd1,
        REG_PERIOD   = 3'd2,
        REG_DUTY     = 3'd3,
        REG_MODE     = 3'd4,
        REG_OUTEN    = 3'd5,
        REG_LATCH    = 3'd6
    } reg_addr_e;

    localparam int CTL_RUN  = 0;
    localparam int CTL_HOLD = 1;
    localparam int CTL_PWM  = 3;

    // Number of match registers: index 0 is the period, index 1 the duty.
    localparam int NUM_MATCH = 2;

endpackage

// File: rtl/pwm_lt_regs.sv
// Module: register file. Holds control, prescale, mode and output enable,
// the shadow and active match registers, and the pending latch flags.
// Assumes: match registers sit at consecutive addresses starting at
// REG_PERIOD; `wrap` is high for exactly the clock of a period restart.
module pwm_lt_regs
    import pwm_lt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [W-1:0]         wr_data,
    input  logic                 wrap,
    output logic                 run,
    output logic                 hold,
    output logic                 pwm_mode,
    output logic                 rop,
    output logic                 oe,
    output logic [W-1:0]         prescale,
    output logic [W-1:0]         act_period,
    output logic [W-1:0]         act_duty,
    output logic [NUM_MATCH-1:0] pend
);

    logic [W-1:0] shadow_q [NUM_MATCH];
    logic [W-1:0] active_q [NUM_MATCH];
    logic         latch_wr;

    // Decode a write to the latch flag register.
    assign latch_wr = wr_en && (wr_addr == REG_LATCH);

    // Control register: run, hold and PWM mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            hold     <= 1'b0;
            pwm_mode <= 1'b0;
        end else if (wr_en && wr_addr == REG_CTRL) begin
            run      <= wr_data[CTL_RUN];
            hold     <= wr_data[CTL_HOLD];
            pwm_mode <= wr_data[CTL_PWM];
        end
    end

    // Prescale register; takes effect at once (not shadowed).
    always_ff @(posedge clk) begin
        if (!rst_n)
            prescale <= '0;
        else if (wr_en && wr_addr == REG_PRESCALE)
            prescale <= wr_data;
    end

    // Mode register: restart-on-period flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rop <= 1'b0;
        else if (wr_en && wr_addr == REG_MODE)
            rop <= wr_data[0];
    end

    // Output enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe <= 1'b0;
        else if (wr_en && wr_addr == REG_OUTEN)
            oe <= wr_data[0];
    end

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
        localparam logic [2:0] MATCH_ADDR = 3'(int'(REG_PERIOD) + m);

        // Shadow match register: loaded by the write port only.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_q[m] <= '0;
            else if (wr_en && wr_addr == MATCH_ADDR)
                shadow_q[m] <= wr_data;
        end

        // Pending flag: a set by write wins over the clear at a wrap.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[m] <= 1'b0;
            else if (latch_wr && wr_data[m])
                pend[m] <= 1'b1;
            else if (wrap)
                pend[m] <= 1'b0;
        end

        // Active match register: takes the shadow value at a flagged wrap.
        always_ff @(posedge clk) begin
            if (!rst_n)
                active_q[m] <= '0;
            else if (wrap && pend[m])
                active_q[m] <= shadow_q[m];
        end
    end

    assign act_period = active_q[0];
    assign act_duty   = active_q[1];

endmodule

// File: rtl/pwm_lt_counter.sv
// Module: prescaler and timer counter. Produces a tick every (prescale+1)
// clocks while running, and a wrap pulse when the next count would reach
// the active period (restart mode only).
// Assumes: hold overrides run; a period of 0 or 1 wraps on every tick.
module pwm_lt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         hold,
    input  logic         rop,
    input  logic [W-1:0] prescale,
    input  logic [W-1:0] act_period,
    output logic [W-1:0] tc,
    output logic         tick,
    output logic         wrap
);

    logic [W-1:0] pc_q;
    logic [W:0]   tc_next;

    // Tick and wrap decode from prescaler, counter and active period.
    always_comb begin
        tc_next = {1'b0, tc} + (W+1)'(1);
        tick    = run && !hold && (pc_q == prescale);
        wrap    = tick && rop && (tc_next >= {1'b0, act_period});
    end

    // Prescale counter: counts clocks up to the prescale value.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            pc_q <= '0;
        else if (run)
            pc_q <= tick ? '0 : pc_q + W'(1);
    end

    // Timer counter: steps on each tick, returns to zero on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            tc <= '0;
        else if (wrap)
            tc <= '0;
        else if (tick)
            tc <= tc_next[W-1:0];
    end

endmodule

// File: rtl/pwm_lt_outstage.sv
// Module: single-edge output stage. Output is high from the duty match to
// the end of the period, gated by PWM mode and output enable.
// Assumes: counter starts every period at zero.
module pwm_lt_outstage #(
    parameter int W = 16
) (
    input  logic         pwm_mode,
    input  logic         oe,
    input  logic [W-1:0] tc,
    input  logic [W-1:0] act_duty,
    output logic         pwm_o
);

    // Level compare and gating onto the pin.
    always_comb begin
        pwm_o = pwm_mode && oe && (tc >= act_duty);
    end

endmodule

// File: rtl/pwm_latched_timer.sv
// Module: top of the period-latched single-edge PWM timer. Wires the
// register file, the counter and the output stage together.
// Assumes: synchronous active-low reset; one write per clock.
module pwm_latched_timer
    import pwm_lt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic         pwm_o,
    output logic [W-1:0] count_o,
    output logic [1:0]   latch_pend_o
);

    logic                 run_w, hold_w, pwm_mode_w, rop_w, oe_w;
    logic                 tick_w, wrap_w;
    logic [W-1:0]         prescale_w, act_period_w, act_duty_w, tc_w;
    logic [NUM_MATCH-1:0] pend_w;

    pwm_lt_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wrap       (wrap_w),
        .run        (run_w),
        .hold       (hold_w),
        .pwm_mode   (pwm_mode_w),
        .rop        (rop_w),
        .oe         (oe_w),
        .prescale   (prescale_w),
        .act_period (act_period_w),
        .act_duty   (act_duty_w),
        .pend       (pend_w)
    );

    pwm_lt_counter #(.W(W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_w),
        .hold       (hold_w),
        .rop        (rop_w),
        .prescale   (prescale_w),
        .act_period (act_period_w),
        .tc         (tc_w),
        .tick       (tick_w),
        .wrap       (wrap_w)
    );

    pwm_lt_outstage #(.W(W)) u_out (
        .pwm_mode (pwm_mode_w),
        .oe       (oe_w),
        .tc       (tc_w),
        .act_duty (act_duty_w),
        .pwm_o    (pwm_o)
    );

    assign count_o      = tc_w;
    assign latch_pend_o = pend_w;

endmodule

// File: rtl/pwm_latched_timer_chk.sv
// Module: assertion checker for the PWM timer, bound to the top module.
// Assumes: reset is held for at least two clocks at start.
module pwm_latched_timer_chk
    import pwm_lt_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic         pwm_o,
    input logic [W-1:0] count_o,
    input logic [1:0]   latch_pend_o,
    input logic         run,
    input logic         hold,
    input logic         pwm_mode,
    input logic         oe,
    input logic [W-1:0] prescale,
    input logic [W-1:0] act_period,
    input logic [W-1:0] act_duty,
    input logic         tick,
    input logic         wrap
);

    // R2: with a nonzero, unchanged prescale, ticks never come back to back.
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && prescale != '0 && !(wr_en && wr_addr == REG_PRESCALE)) |=> !tick);

    // R3: a tick that is not a wrap moves the counter up by one.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wrap) |=> (count_o == $past(count_o) + W'(1)));

    // R5: without a wrap the active match values do not move.
    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(act_period) && $stable(act_duty)));

    // R6: a wrap with no latch write clears all pending flags.
    assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !(wr_en && wr_addr == REG_LATCH)) |=> (latch_pend_o == 2'b00));

    // R7: a stopped counter keeps its value.
    assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !hold) |=> $stable(count_o));

    // R8: hold forces the counter to zero on the next clock.
    assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (count_o == '0));

    // R9: output low whenever gating is off.
    assert_gated_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode || !oe) |-> !pwm_o);

endmodule

bind pwm_latched_timer pwm_latched_timer_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .pwm_o        (pwm_o),
    .count_o      (count_o),
    .latch_pend_o (latch_pend_o),
    .run          (run_w),
    .hold         (hold_w),
    .pwm_mode     (pwm_mode_w),
    .oe           (oe_w),
    .prescale     (prescale_w),
    .act_period   (act_period_w),
    .act_duty     (act_duty_w),
    .tick         (tick_w),
    .wrap         (wrap_w)
);

// File: tb/pwm_latched_timer_test.sv
module pwm_latched_timer_test;

    localparam int W = 16;
    localparam int NV = 7;
    // Vector table: prescale, period, duty.
    localparam int VPRE [NV] = '{0, 0, 1, 3, 0, 2, 0};
    localparam int VPER [NV] = '{2, 10, 5, 4, 6, 5, 1};
    localparam int VDUT [NV] = '{1, 3, 2, 1, 0, 7, 1};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_o;
    logic [W-1:0] count_o;
    logic [1:0]   latch_pend_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_latched_timer #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_o(pwm_o), .count_o(count_o),
        .latch_pend_o(latch_pend_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One write; returns at the falling edge after the capturing edge.
    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = 3'(addr);
        wr_data = W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count high samples and the peak counter value over n clocks.
    task automatic measure(input int n, output int highs, output int peak);
        highs = 0;
        peak = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_o) highs++;
            if (int'(count_o) > peak) peak = int'(count_o);
        end
    endtask

    task automatic configure(input int pre, input int per, input int duty);
        wr(0, 'h0A);
        wr(1, pre);
        wr(2, per);
        wr(3, duty);
        wr(4, 1);
        wr(5, 1);
        wr(6, 3);
        wr(0, 'h09);
        repeat (100) @(negedge clk);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int hi, pk, c0, s1, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 count", int'(count_o), 0);
        chk("R1 pwm", int'(pwm_o), 0);
        chk("R1 pend", int'(latch_pend_o), 0);

        // R3 R4: table walk over whole periods
        for (int v = 0; v < NV; v++) begin
            int plen, exph;
            configure(VPRE[v], VPER[v], VDUT[v]);
            plen = VPER[v] * (VPRE[v] + 1);
            exph = (VDUT[v] < VPER[v]) ? (VPER[v] - VDUT[v]) * (VPRE[v] + 1) : 0;
            measure(4 * plen, hi, pk);
            chk($sformatf("R4 highs vec%0d", v), hi, 4 * exph);
            chk($sformatf("R3 peak vec%0d", v), pk, VPER[v] - 1);
            if (v == 0) begin
                @(negedge clk); s1 = int'(pwm_o);
                @(negedge clk); s2 = int'(pwm_o);
                chk("R4 half clock toggle", int'(s1 != s2), 1);
            end
        end

        // R5: shadow writes without latch do not apply
        configure(0, 50, 10);
        wr(2, 4);
        wr(3, 2);
        measure(120, hi, pk);
        chk("R5 period kept", pk, 49);
        chk("R6 no pend", int'(latch_pend_o), 0);
        wr(6, 0);
        chk("R6 zero write", int'(latch_pend_o), 0);
        wr(6, 1);
        chk("R6 set period flag", int'(latch_pend_o), 1);
        repeat (60) @(negedge clk);
        chk("R6 self clear", int'(latch_pend_o), 0);
        measure(40, hi, pk);
        chk("R5 period applied", pk, 3);
        chk("R5 duty not applied", hi, 0);
        wr(6, 2);
        repeat (20) @(negedge clk);
        measure(40, hi, pk);
        chk("R5 duty applied", hi, 20);

        // R6 R8: flags accumulate under hold, counter held
        wr(0, 'h0B);
        wr(6, 2);
        wr(6, 1);
        chk("R6 accumulate", int'(latch_pend_o), 3);
        measure(20, hi, pk);
        chk("R8 hold count", pk, 0);
        chk("R8 no transfer", int'(latch_pend_o), 3);

        // R2: prescale 2 from hold release
        wr(1, 2);
        wr(0, 'h09);
        chk("R2 after release", int'(count_o), 0);
        repeat (2) @(negedge clk);
        chk("R2 before tick", int'(count_o), 0);
        @(negedge clk);
        chk("R2 first tick", int'(count_o), 1);
        repeat (3) @(negedge clk);
        chk("R2 second tick", int'(count_o), 2);

        // R7: stop keeps the count
        wr(0, 'h08);
        c0 = int'(count_o);
        repeat (20) @(negedge clk);
        chk("R7 stopped", int'(count_o), c0);

        // R9: gating
        wr(0, 'h01);
        measure(48, hi, pk);
        chk("R9 pwm mode off", hi, 0);
        chk("R7 runs with bit0", int'(pk > 0), 1);
        wr(0, 'h09);
        wr(5, 0);
        measure(48, hi, pk);
        chk("R9 output disabled", hi, 0);
        wr(5, 1);
        measure(48, hi, pk);
        chk("R4 enabled highs", hi, 24);

        // R3: free run without restart
        wr(0, 'h0A);
        wr(1, 0);
        wr(4, 0);
        wr(0, 'h09);
        repeat (29) @(negedge clk);
        chk("R3 free run", int'(count_o), 29);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule